// File: doc/BRIEF.md
# Retriggerable Buffered PWM Timer

This block is a down-counting pulse-width generator. Each run loads the counter from a period register. The counter then steps down once per count-enable strobe, which comes from an external clock divider. The output starts each cycle LOW and goes HIGH once the counter has reached the duty value. At underflow it goes LOW again, and the period and duty are reloaded from their buffers. Software writes a control word, the two buffer registers and a flag register through a single-cycle write port.

A run starts on a software trigger or on a chosen edge of an external trigger input. The block can run continuously or stop after one cycle. While a run is in progress, a further trigger can either restart the cycle or be ignored. The output can be inverted or held at its idle level. Three sticky event flags (trigger, duty match, underflow) are ANDed with their enables and ORed into a single interrupt request.

The controller has two states. ST_IDLE is the reset state and the state after a stop. ST_RUN is the counting state. The transitions are start (ST_IDLE to ST_RUN on an accepted trigger), restart (ST_RUN to ST_RUN, counter reloaded by a trigger), wrap (ST_RUN to ST_RUN at underflow in continuous mode), finish (ST_RUN to ST_IDLE at underflow in one-shot mode) and halt (any state to ST_IDLE when the enable bit is written 0).

Top module: `retrig_pwm`

## Requirements
- R1: The write port selects a register with wr_sel: 0 is control, 1 is period P, 2 is duty D and 3 is flags. In ST_RUN, the counter drops by one on every cycle with cnt_tick high. From an accepted trigger, it holds P for one tick, then P-1, and so on down to 0, so one cycle lasts P+1 ticks.
- R2: With normal polarity, the output is HIGH while running and the counter is at or below D, and LOW otherwise. The HIGH time is therefore D+1 ticks. D equal to P gives a cycle that is HIGH throughout. D equal to 0 gives a one-tick HIGH pulse.
- R3: The counter loads P from the period buffer at start, at restart and at every underflow. While the timer runs, a duty write is held in a buffer and reaches the compare value only at underflow. While the timer is idle, a duty write takes effect at once.
- R4: Control bit 0 is the enable and bit 1 is a software trigger. A control write with both bits at 1 is a trigger; with bit 0 at 0, bit 1 has no effect. Control bits 7:6 select the external trigger edge: 00 none, 01 rising, 10 falling, 11 both. The external input is synchronized by two flip-flops, so a change made before clock edge k takes effect at edge k+2. The external input is ignored while the stored enable is 0.
- R5: When control bit 3 (restart enable) is 1, a trigger during ST_RUN reloads P and begins a new cycle with the output LOW. On the same tick, the trigger takes priority over an underflow or duty match.
- R6: When control bit 3 is 0, a trigger during ST_RUN has no effect on the counter, the output or the flags.
- R7: When control bit 2 (one-shot) is 0, the timer wraps at underflow and keeps running. When it is 1, the timer returns to ST_IDLE at the first underflow and the output returns to its idle level.
- R8: Control bit 4 inverts the output, which makes the idle level HIGH instead of LOW. Control bit 5 forces the output to the idle level.
- R9: A control write with bit 0 at 0 puts the timer in ST_IDLE on that clock edge. This takes priority over any trigger in the same cycle.
- R10: Flag bit 0 is set by an accepted trigger. Flag bit 1 is set by a tick while the counter equals the duty value. Flag bit 2 is set by underflow. The flags are sticky and reset to 0. A write to the flag register clears the bits written 0 and keeps the bits written 1. An event in the same cycle as a clear wins.
- R11: Control bits 8, 9 and 10 enable flags 0, 1 and 2. irq is high exactly when an enabled flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 control, 1 period, 2 duty, 3 flags |
| wr_data | input | DATA_W | Write data |
| cnt_tick | input | 1 | Count enable from the clock divider |
| ext_trig | input | 1 | Asynchronous external trigger |
| pwm_out | output | 1 | PWM output after polarity and mask |
| irq | output | 1 | Interrupt request |
| evt_flags | output | 3 | Sticky flags: 0 trigger, 1 duty match, 2 underflow |

## Verification
The interesting collision is a restart trigger arriving on the same tick as an underflow or a duty match. The bench issues software triggers at a sweep of offsets into a short continuous cycle, so that some of them land exactly on the reload tick. A behavioural reference model, checked on every clock, judges the result: the reload must win, neither the underflow flag nor the duty match flag may set on that tick, and the buffered duty must not be transferred. A second collision, a flag clear in the same cycle as that flag's event, is covered by the same model across the flag-write sequences.

// File: rtl/rpwm_pkg.sv
package rpwm_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } rpwm_state_e;

    localparam int FLAG_N   = 3;
    localparam int FLG_TRIG = 0;
    localparam int FLG_DUTY = 1;
    localparam int FLG_UF   = 2;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_PER  = 2'd1;
    localparam logic [1:0] SEL_DUTY = 2'd2;
    localparam logic [1:0] SEL_FLAG = 2'd3;

    localparam int CB_EN  = 0;
    localparam int CB_SW  = 1;
    localparam int CB_ONE = 2;
    localparam int CB_RST = 3;
    localparam int CB_INV = 4;
    localparam int CB_MSK = 5;
    localparam int CB_SEL = 6;
    localparam int CB_IE  = 8;

    typedef struct packed {
        logic [FLAG_N-1:0] ie;
        logic [1:0]        edge_sel;
        logic              mask;
        logic              invert;
        logic              restart_en;
        logic              oneshot;
        logic              enable;
    } rpwm_ctrl_t;

endpackage

// File: rtl/rpwm_trig.sv
module rpwm_trig #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ext_i,
    input  logic [1:0] edge_sel,
    input  logic       enable,
    input  logic       sw_fire,
    output logic       fire
);
    localparam int LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   ext_hit;

    generate
        for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_sync
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= ext_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[i] <= 1'b0;
                    else        sync_q[i] <= sync_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[LAST];
    end

    always_comb begin
        unique case (edge_sel)
            2'b00: ext_hit = 1'b0;
            2'b01: ext_hit = sync_q[LAST] & ~prev_q;
            2'b10: ext_hit = ~sync_q[LAST] & prev_q;
            2'b11: ext_hit = sync_q[LAST] ^ prev_q;
        endcase
    end

    assign fire = sw_fire | (enable & ext_hit);

endmodule

// File: rtl/rpwm_core.sv
module rpwm_core
    import rpwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             fire,
    input  logic             halt,
    input  logic             oneshot,
    input  logic             restart_en,
    input  logic [CNT_W-1:0] per_buf,
    input  logic [CNT_W-1:0] duty_buf,
    input  logic             duty_wr,
    input  logic [CNT_W-1:0] duty_wdata,
    output logic             run,
    output logic [CNT_W-1:0] cnt,
    output logic             raw,
    output logic             evt_trig,
    output logic             evt_duty,
    output logic             evt_uf
);
    rpwm_state_e      state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] duty_q, duty_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            duty_q  <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            duty_q  <= duty_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        duty_d   = duty_q;
        evt_trig = 1'b0;
        evt_duty = 1'b0;
        evt_uf   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (!halt && fire) begin          // start
                    state_d  = ST_RUN;
                    cnt_d    = per_buf;
                    evt_trig = 1'b1;
                end
            end
            ST_RUN: begin
                if (halt) begin                   // halt
                    state_d = ST_IDLE;
                end else if (fire && restart_en) begin  // restart
                    cnt_d    = per_buf;
                    evt_trig = 1'b1;
                end else if (tick) begin
                    if (cnt_q == duty_q) evt_duty = 1'b1;
                    if (cnt_q == '0) begin        // wrap or finish
                        evt_uf = 1'b1;
                        cnt_d  = per_buf;
                        duty_d = duty_buf;
                        if (oneshot) state_d = ST_IDLE;
                    end else begin
                        cnt_d = cnt_q - 1'b1;
                    end
                end
            end
        endcase
        if (duty_wr && state_q == ST_IDLE) duty_d = duty_wdata;
    end

    always_comb begin
        run = (state_q == ST_RUN);
        cnt = cnt_q;
        raw = run && (cnt_q <= duty_q);
    end

endmodule

// File: rtl/rpwm_regs.sv
module rpwm_regs
    import rpwm_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [FLAG_N-1:0] evt,
    output rpwm_ctrl_t        ctrl,
    output logic [CNT_W-1:0]  per_buf,
    output logic [CNT_W-1:0]  duty_buf,
    output logic              sw_fire,
    output logic              halt,
    output logic              duty_wr,
    output logic [FLAG_N-1:0] flags,
    output logic              irq
);
    logic              wr_ctrl;
    logic [FLAG_N-1:0] flags_d;

    assign wr_ctrl = wr_en && (wr_sel == SEL_CTRL);
    assign sw_fire = wr_ctrl && wr_data[CB_EN] && wr_data[CB_SW];
    assign halt    = wr_ctrl && !wr_data[CB_EN];
    assign duty_wr = wr_en && (wr_sel == SEL_DUTY);

    always_comb begin
        flags_d = flags;
        if (wr_en && wr_sel == SEL_FLAG) flags_d = flags_d & wr_data[FLAG_N-1:0];
        flags_d = flags_d | evt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl     <= '0;
            per_buf  <= '0;
            duty_buf <= '0;
            flags    <= '0;
        end else begin
            flags <= flags_d;
            if (wr_ctrl) begin
                ctrl.enable     <= wr_data[CB_EN];
                ctrl.oneshot    <= wr_data[CB_ONE];
                ctrl.restart_en <= wr_data[CB_RST];
                ctrl.invert     <= wr_data[CB_INV];
                ctrl.mask       <= wr_data[CB_MSK];
                ctrl.edge_sel   <= wr_data[CB_SEL +: 2];
                ctrl.ie         <= wr_data[CB_IE +: FLAG_N];
            end
            if (wr_en && wr_sel == SEL_PER) per_buf  <= wr_data[CNT_W-1:0];
            if (duty_wr)                    duty_buf <= wr_data[CNT_W-1:0];
        end
    end

    assign irq = |(flags & ctrl.ie);

endmodule

// File: rtl/retrig_pwm.sv
module retrig_pwm
    import rpwm_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cnt_tick,
    input  logic              ext_trig,
    output logic              pwm_out,
    output logic              irq,
    output logic [2:0]        evt_flags
);
    rpwm_ctrl_t        ctrl;
    logic [CNT_W-1:0]  per_buf, duty_buf, core_cnt;
    logic              sw_fire, halt, duty_wr, fire;
    logic              core_run, core_raw;
    logic              evt_trig, evt_duty, evt_uf;
    logic [FLAG_N-1:0] evt, flags;

    assign evt[FLG_TRIG] = evt_trig;
    assign evt[FLG_DUTY] = evt_duty;
    assign evt[FLG_UF]   = evt_uf;

    rpwm_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .evt(evt), .ctrl(ctrl), .per_buf(per_buf), .duty_buf(duty_buf),
        .sw_fire(sw_fire), .halt(halt), .duty_wr(duty_wr), .flags(flags), .irq(irq)
    );

    rpwm_trig #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
        .clk(clk), .rst_n(rst_n), .ext_i(ext_trig), .edge_sel(ctrl.edge_sel),
        .enable(ctrl.enable), .sw_fire(sw_fire), .fire(fire)
    );

    rpwm_core #(.CNT_W(CNT_W)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(cnt_tick), .fire(fire), .halt(halt),
        .oneshot(ctrl.oneshot), .restart_en(ctrl.restart_en),
        .per_buf(per_buf), .duty_buf(duty_buf), .duty_wr(duty_wr),
        .duty_wdata(wr_data[CNT_W-1:0]), .run(core_run), .cnt(core_cnt),
        .raw(core_raw), .evt_trig(evt_trig), .evt_duty(evt_duty), .evt_uf(evt_uf)
    );

    always_comb begin
        if (ctrl.mask) pwm_out = ctrl.invert;
        else           pwm_out = core_raw ^ ctrl.invert;
    end

    assign evt_flags = flags;

endmodule

// File: rtl/rpwm_chk.sv
module rpwm_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_tick,
    input logic             halt,
    input logic             flag_wr,
    input logic             run,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] per_buf,
    input logic             oneshot,
    input logic             restart_en,
    input logic             fire,
    input logic [2:0]       flags
);
    // R1: one step down per tick
    a_r1_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt_tick && cnt != '0 && !fire && !halt) |=> (cnt == CNT_W'($past(cnt) - 1'b1)));

    // R3 / R4: start loads the period buffer
    a_r4_start_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && fire && !halt) |=> (run && cnt == $past(per_buf)));

    // R6: trigger without restart leaves the counter alone
    a_r6_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !restart_en && fire && !halt && !cnt_tick) |=> (run && cnt == $past(cnt)));

    // R7: one-shot finishes at underflow
    a_r7_oneshot_end: assert property (@(posedge clk) disable iff (!rst_n)
        (run && oneshot && cnt_tick && cnt == '0 && !fire && !halt) |=> !run);

    // R7: continuous wraps to the period
    a_r7_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !oneshot && cnt_tick && cnt == '0 && !fire && !halt) |=> (run && cnt == $past(per_buf)));

    // R9: halt stops at once
    a_r9_halt: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> !run);

    // R10: underflow flag is sticky
    a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[2] && !flag_wr) |=> flags[2]);

endmodule

bind retrig_pwm rpwm_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick),
    .halt(wr_en && wr_sel == 2'd0 && !wr_data[0]),
    .flag_wr(wr_en && wr_sel == 2'd3),
    .run(core_run), .cnt(core_cnt), .per_buf(per_buf),
    .oneshot(ctrl.oneshot), .restart_en(ctrl.restart_en),
    .fire(fire), .flags(evt_flags)
);

// File: tb/tb_retrig_pwm.sv
module tb_retrig_pwm;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [15:0] wr_data = 16'd0;
    logic        cnt_tick = 1'b0;
    logic        ext_trig = 1'b0;
    logic        pwm_out, irq;
    logic [2:0]  evt_flags;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int tick_div = 1;
    bit done = 0;
    string cur_req = "R10";

    // model state
    int m_run, m_cnt, m_per, m_dbuf, m_dact, m_flags;
    int m_en, m_one, m_rst, m_inv, m_msk, m_sel, m_ie;
    int hist[$];
    int s2, pv, hit, fire, halt, e_t, e_d, e_u, wc, m_raw, x_pwm, x_irq;

    retrig_pwm dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .cnt_tick(cnt_tick), .ext_trig(ext_trig), .pwm_out(pwm_out), .irq(irq),
        .evt_flags(evt_flags)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            m_run = 0; m_cnt = 0; m_per = 0; m_dbuf = 0; m_dact = 0; m_flags = 0;
            m_en = 0; m_one = 0; m_rst = 0; m_inv = 0; m_msk = 0; m_sel = 0; m_ie = 0;
            hist = '{0, 0, 0};
        end else begin
            s2 = hist[1]; pv = hist[2];
            case (m_sel)
                0: hit = 0;
                1: hit = (s2 == 1 && pv == 0);
                2: hit = (s2 == 0 && pv == 1);
                default: hit = (s2 != pv);
            endcase
            wc   = (wr_en && wr_sel == 0);
            halt = wc && !wr_data[0];
            fire = (wc && wr_data[0] && wr_data[1]) || (m_en && hit);
            e_t = 0; e_d = 0; e_u = 0;
            if (halt) m_run = 0;
            else if (fire && (!m_run || m_rst)) begin
                m_run = 1; m_cnt = m_per; e_t = 1;
            end else if (m_run && cnt_tick) begin
                if (m_cnt == m_dact) e_d = 1;
                if (m_cnt == 0) begin
                    e_u = 1; m_cnt = m_per; m_dact = m_dbuf;
                    if (m_one) m_run = 0;
                end else m_cnt = m_cnt - 1;
            end
            if (wr_en && wr_sel == 2 && !(m_run || e_t)) m_dact = wr_data;
            if (wr_en && wr_sel == 2 && e_t && !halt && !fire) m_dact = m_dact;
            if (wc) begin
                m_en = wr_data[0]; m_one = wr_data[2]; m_rst = wr_data[3];
                m_inv = wr_data[4]; m_msk = wr_data[5]; m_sel = wr_data[7:6];
                m_ie = wr_data[10:8];
            end
            if (wr_en && wr_sel == 1) m_per = wr_data;
            if (wr_en && wr_sel == 2) m_dbuf = wr_data;
            if (wr_en && wr_sel == 3) m_flags = m_flags & wr_data[2:0];
            m_flags = m_flags | e_t | (e_d << 1) | (e_u << 2);
            hist.push_front(int'(ext_trig));
            void'(hist.pop_back());
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            m_raw = (m_run && m_cnt <= m_dact);
            x_pwm = m_msk ? m_inv : (m_raw ^ m_inv);
            x_irq = ((m_flags & m_ie) != 0);
            check(cur_req, "pwm_out", int'(pwm_out), x_pwm);
            check("R11", "irq", int'(irq), x_irq);
            check("R10", "flags", int'(evt_flags), m_flags);
        end
    end

    // tick generator
    initial begin
        forever begin
            @(negedge clk);
            cnt_tick = (tick_div <= 1) ? 1'b1 : ((cyc % tick_div) == 0);
        end
    end

    // watchdog
    initial begin
        wait (cyc > 100000);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic wr(input logic [1:0] sel, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 16'd0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic ext_set(input logic v);
        @(negedge clk);
        ext_trig = v;
    endtask

    initial begin
        int hi;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state (R10, R2)
        check("R2", "reset pwm", int'(pwm_out), 0);
        check("R10", "reset flags", int'(evt_flags), 0);
        check("R11", "reset irq", int'(irq), 0);

        // R1 / R2: continuous, P=9 D=3
        cur_req = "R1";
        wr(1, 16'd9); wr(2, 16'd3);
        wr(0, 16'h0701); wr(0, 16'h0703);
        idle(25);
        cur_req = "R2";
        hi = 0;
        repeat (10) begin @(negedge clk); hi += int'(pwm_out); end
        check("R2", "high ticks per 10-tick cycle", hi, 4);
        tick_div = 3;  // R1 with slow ticks
        cur_req = "R1";
        idle(70);
        tick_div = 1;

        // R3: buffered updates while running; D=P and D=0
        cur_req = "R3";
        wr(1, 16'd5); wr(2, 16'd5);
        idle(25);
        cur_req = "R2";
        wr(2, 16'd0);
        idle(20);

        // R10: selective clear
        cur_req = "R10";
        wr(3, 16'h0006); idle(3);
        wr(3, 16'h0000); idle(12);

        // R8: invert and mask
        cur_req = "R8";
        wr(2, 16'd2);
        wr(0, 16'h0711); idle(20);
        wr(0, 16'h0731); idle(10);
        wr(0, 16'h0721); idle(10);
        wr(0, 16'h0701); idle(10);

        // R5: restart enabled, sweep trigger offsets
        cur_req = "R5";
        wr(1, 16'd6); wr(2, 16'd2);
        wr(0, 16'h0709);
        for (int off = 0; off < 12; off++) begin
            idle(off);
            wr(0, 16'h070B);
        end
        idle(10);

        // R6: restart disabled
        cur_req = "R6";
        wr(0, 16'h0701);
        for (int off = 0; off < 10; off++) begin
            idle(off);
            wr(0, 16'h0703);
        end
        idle(10);

        // R7: one-shot
        cur_req = "R7";
        wr(0, 16'h0000);
        wr(1, 16'd4); wr(2, 16'd1);
        wr(0, 16'h0705); wr(0, 16'h0707);
        idle(15);
        wr(0, 16'h070F); idle(2); wr(0, 16'h070F); idle(15);

        // R4: enable 0 blocks sw trigger and external edges
        cur_req = "R4";
        wr(0, 16'h07C2); idle(3);
        ext_set(1); idle(6); ext_set(0); idle(6);
        for (int s = 0; s < 4; s++) begin
            wr(0, 16'(16'h0705 | (s << 6)));
            ext_set(1); idle(12);
            ext_set(0); idle(12);
        end
        // restart via external edge with slow ticks
        wr(0, 16'h07CD);
        tick_div = 2;
        ext_set(1); idle(5); ext_set(0); idle(3); ext_set(1); idle(20);
        tick_div = 1;

        // R9: halt mid-run, halt racing a trigger
        cur_req = "R9";
        wr(1, 16'd20); wr(2, 16'd15);
        wr(0, 16'h0701); wr(0, 16'h0703); idle(8);
        wr(0, 16'h0000);
        @(negedge clk);
        check("R9", "pwm after halt", int'(pwm_out), 0);
        wr(0, 16'h00C1); ext_set(0); idle(3);
        ext_set(1); idle(1);
        wr(0, 16'h00C0); idle(8);

        // R11: partial enables
        cur_req = "R11";
        wr(1, 16'd3); wr(2, 16'd1);
        wr(3, 16'h0000);
        wr(0, 16'h0201); wr(0, 16'h0203); idle(10);
        wr(3, 16'h0000); wr(0, 16'h0401); idle(10);
        wr(0, 16'h0001); wr(3, 16'h0000); idle(5);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule